// File: doc/BRIEF.md
# Banked Stack Pointer Unit

This block keeps two separate stack pointers: a main pointer and a process pointer. One of them is the active pointer at any time. The choice depends on the processor mode and on a stored select bit. In handler mode the main pointer is always active. In thread mode the select bit chooses between the two. Reset leaves the block in thread mode with the select bit clear, so the main pointer starts out active.

Push and pop requests use a full-descending stack, which means the active pointer always addresses the item stored most recently.
- **Push:** the block issues a memory write at the active pointer minus one word. The pointer takes that lower value on the next clock.
- **Pop:** the block issues a memory read at the active pointer. The pointer then moves up by one word.

The memory request is combinational from the request inputs. Pointer and mode state are registered. Mode entry and exit events come from the exception sequencer. Software-style writes load either banked pointer directly or change the select bit.

Top module: `bsp_unit`

## Requirements
- R1: After reset the unit is in thread mode and the select bit is clear. The main pointer holds MAIN_RST and the process pointer holds PROC_RST. The active pointer equals the main pointer.
- R2: In thread mode the active pointer is the process pointer when the stored select bit is 1, and the main pointer when it is 0.
- R3: In handler mode the active pointer is always the main pointer, whatever the value of the select bit.
- R4: A push issues a write in the same cycle. `mem_we_o` is 1, `mem_addr_o` is the active pointer minus 4, and `mem_wdata_o` is the push data. On the next cycle the active pointer equals that address, wrapping modulo 2^AW. The inactive pointer does not change.
- R5: A pop issues a read in the same cycle. `mem_re_o` is 1 and `mem_addr_o` is the active pointer. On the next cycle the active pointer is 4 higher.
- R6: A push and a pop in the same cycle raise `err_o` in that cycle. No memory write or read is issued, and neither pointer changes.
- R7: Pointer bits [1:0] always read as zero. A direct write stores the written value with those two bits dropped.
- R8: A write to the select bit while in handler mode is stored. It affects pointer selection only after the unit returns to thread mode.
- R9: A mode entry event puts the unit in handler mode on the next cycle, and an exit event returns it to thread mode. If both arrive in the same cycle, entry wins.
- R10: A direct write to a pointer in the same cycle as a push or pop on that pointer takes priority over the step. The memory request is still issued from the old pointer value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| exc_enter_i | input | 1 | Enter handler mode |
| exc_exit_i | input | 1 | Return to thread mode |
| ctrl_wr_i | input | 1 | Write strobe for the select bit |
| ctrl_val_i | input | 1 | Select bit value (1 = process pointer in thread mode) |
| msp_wr_i | input | 1 | Direct write to the main pointer |
| psp_wr_i | input | 1 | Direct write to the process pointer |
| sp_wdata_i | input | AW | Value for direct pointer writes |
| push_i | input | 1 | Push request |
| push_data_i | input | DW | Data to store on a push |
| pop_i | input | 1 | Pop request |
| active_sp_o | output | AW | Currently active pointer |
| msp_o | output | AW | Main pointer |
| psp_o | output | AW | Process pointer |
| handler_o | output | 1 | 1 while in handler mode |
| ctrl_o | output | 1 | Stored select bit |
| mem_addr_o | output | AW | Memory request address |
| mem_wdata_o | output | DW | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read strobe |
| err_o | output | 1 | Push and pop requested together |

## Verification
A wrong mode or select bit shows at the ports as a wrong `active_sp_o` in the cycle after the event. It also shows as a memory request aimed at the wrong bank on the next push or pop. A wrong step or a wrong bank update shows as an incorrect `mem_addr_o` on the next request, and as a drifted pointer one cycle after the request. The bench keeps an independent model of both pointers, the mode and the select bit. It compares every memory request against that model in the cycle the request is issued, and it compares all pointer state after every operation.

// File: rtl/bsp_pkg.sv
package bsp_pkg;
   typedef enum logic [1:0] {
      OP_IDLE  = 2'd0,
      OP_PUSH  = 2'd1,
      OP_POP   = 2'd2,
      OP_CLASH = 2'd3
   } sp_op_e;

   localparam int BANK_MAIN = 0;
   localparam int BANK_PROC = 1;
   localparam int NUM_BANKS = 2;
endpackage

// File: rtl/bsp_bank.sv
module bsp_bank #(
   parameter int             AW      = 32,
   parameter int             LSB     = 2,
   parameter logic [AW-1:0]  RST_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:LSB]   wr_val,
   input  logic              upd_en,
   input  logic [AW-1:LSB]   upd_val,
   output logic [AW-1:0]     sp_o
);
   logic [AW-1:LSB] sp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sp_q <= RST_VAL[AW-1:LSB];
      else if (wr_en)
         sp_q <= wr_val;
      else if (upd_en)
         sp_q <= upd_val;
   end

   assign sp_o = {sp_q, {LSB{1'b0}}};
endmodule

// File: rtl/bsp_mode_ctrl.sv
module bsp_mode_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic enter_i,
   input  logic exit_i,
   input  logic ctl_wr_i,
   input  logic ctl_val_i,
   output logic handler_o,
   output logic ctl_o,
   output logic use_proc_o
);
   logic handler_q;
   logic ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         handler_q <= 1'b0;
         ctl_q     <= 1'b0;
      end else begin
         if (enter_i)
            handler_q <= 1'b1;
         else if (exit_i)
            handler_q <= 1'b0;
         if (ctl_wr_i)
            ctl_q <= ctl_val_i;
      end
   end

   assign handler_o  = handler_q;
   assign ctl_o      = ctl_q;
   assign use_proc_o = ctl_q & ~handler_q;
endmodule

// File: rtl/bsp_op_decode.sv
module bsp_op_decode
   import bsp_pkg::*;
#(
   parameter int AW  = 32,
   parameter int DW  = 32,
   parameter int LSB = 2
) (
   input  logic            push_i,
   input  logic            pop_i,
   input  logic [DW-1:0]   push_data_i,
   input  logic [AW-1:0]   active_sp_i,
   output sp_op_e          op_o,
   output logic            err_o,
   output logic            mem_we_o,
   output logic            mem_re_o,
   output logic [AW-1:0]   mem_addr_o,
   output logic [DW-1:0]   mem_wdata_o,
   output logic            upd_en_o,
   output logic [AW-1:LSB] upd_val_o
);
   localparam logic [AW-1:0] STEP = AW'(1) << LSB;

   logic [AW-1:0] dec_sp;
   logic [AW-1:0] inc_sp;

   assign dec_sp = active_sp_i - STEP;
   assign inc_sp = active_sp_i + STEP;

   always_comb begin
      unique case ({pop_i, push_i})
         2'b01:   op_o = OP_PUSH;
         2'b10:   op_o = OP_POP;
         2'b11:   op_o = OP_CLASH;
         default: op_o = OP_IDLE;
      endcase
   end

   always_comb begin
      mem_we_o    = 1'b0;
      mem_re_o    = 1'b0;
      err_o       = 1'b0;
      upd_en_o    = 1'b0;
      mem_addr_o  = active_sp_i;
      mem_wdata_o = '0;
      upd_val_o   = active_sp_i[AW-1:LSB];
      case (op_o)
         OP_PUSH: begin
            mem_we_o    = 1'b1;
            mem_addr_o  = dec_sp;
            mem_wdata_o = push_data_i;
            upd_en_o    = 1'b1;
            upd_val_o   = dec_sp[AW-1:LSB];
         end
         OP_POP: begin
            mem_re_o    = 1'b1;
            upd_en_o    = 1'b1;
            upd_val_o   = inc_sp[AW-1:LSB];
         end
         OP_CLASH: err_o = 1'b1;
         default: ;
      endcase
   end
endmodule

// File: rtl/bsp_unit.sv
module bsp_unit
   import bsp_pkg::*;
#(
   parameter int            AW        = 32,
   parameter int            DW        = 32,
   parameter int            ALIGN_LSB = 2,
   parameter logic [AW-1:0] MAIN_RST  = 32'h2000_1000,
   parameter logic [AW-1:0] PROC_RST  = 32'h2000_0800
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          exc_enter_i,
   input  logic          exc_exit_i,
   input  logic          ctrl_wr_i,
   input  logic          ctrl_val_i,
   input  logic          msp_wr_i,
   input  logic          psp_wr_i,
   input  logic [AW-1:0] sp_wdata_i,
   input  logic          push_i,
   input  logic [DW-1:0] push_data_i,
   input  logic          pop_i,
   output logic [AW-1:0] active_sp_o,
   output logic [AW-1:0] msp_o,
   output logic [AW-1:0] psp_o,
   output logic          handler_o,
   output logic          ctrl_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [DW-1:0] mem_wdata_o,
   output logic          mem_we_o,
   output logic          mem_re_o,
   output logic          err_o
);
   localparam int LSB = ALIGN_LSB;

   if (AW < 8 || AW > 64) begin : g_bad_aw
      $error("bsp_unit: AW out of range");
   end
   if (LSB < 1 || LSB >= AW - 4) begin : g_bad_lsb
      $error("bsp_unit: ALIGN_LSB out of range");
   end
   if (MAIN_RST[LSB-1:0] != '0 || PROC_RST[LSB-1:0] != '0) begin : g_bad_rst
      $error("bsp_unit: reset pointers must be aligned");
   end

   logic                 use_proc;
   logic                 upd_en;
   logic [AW-1:LSB]      upd_val;
   sp_op_e               op;
   logic [NUM_BANKS-1:0] bank_wr;
   logic [AW-1:0]        bank_sp [NUM_BANKS];

   assign bank_wr[BANK_MAIN] = msp_wr_i;
   assign bank_wr[BANK_PROC] = psp_wr_i;

   bsp_mode_ctrl u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .enter_i    (exc_enter_i),
      .exit_i     (exc_exit_i),
      .ctl_wr_i   (ctrl_wr_i),
      .ctl_val_i  (ctrl_val_i),
      .handler_o  (handler_o),
      .ctl_o      (ctrl_o),
      .use_proc_o (use_proc)
   );

   for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
      localparam logic [AW-1:0] RV = (g == BANK_MAIN) ? MAIN_RST : PROC_RST;
      logic sel_here;
      assign sel_here = (g == BANK_PROC) ? use_proc : ~use_proc;
      bsp_bank #(
         .AW      (AW),
         .LSB     (LSB),
         .RST_VAL (RV)
      ) u_bank (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (bank_wr[g]),
         .wr_val  (sp_wdata_i[AW-1:LSB]),
         .upd_en  (upd_en & sel_here),
         .upd_val (upd_val),
         .sp_o    (bank_sp[g])
      );
   end

   assign msp_o       = bank_sp[BANK_MAIN];
   assign psp_o       = bank_sp[BANK_PROC];
   assign active_sp_o = use_proc ? psp_o : msp_o;

   bsp_op_decode #(
      .AW  (AW),
      .DW  (DW),
      .LSB (LSB)
   ) u_dec (
      .push_i      (push_i),
      .pop_i       (pop_i),
      .push_data_i (push_data_i),
      .active_sp_i (active_sp_o),
      .op_o        (op),
      .err_o       (err_o),
      .mem_we_o    (mem_we_o),
      .mem_re_o    (mem_re_o),
      .mem_addr_o  (mem_addr_o),
      .mem_wdata_o (mem_wdata_o),
      .upd_en_o    (upd_en),
      .upd_val_o   (upd_val)
   );
endmodule

// File: rtl/bsp_unit_chk.sv
module bsp_unit_chk #(
   parameter int AW  = 32,
   parameter int LSB = 2
) (
   input logic          clk,
   input logic          rst_n,
   input logic          exc_enter_i,
   input logic          exc_exit_i,
   input logic          ctrl_wr_i,
   input logic          msp_wr_i,
   input logic          psp_wr_i,
   input logic [AW-1:0] sp_wdata_i,
   input logic          push_i,
   input logic          pop_i,
   input logic [AW-1:0] active_sp_o,
   input logic [AW-1:0] msp_o,
   input logic [AW-1:0] psp_o,
   input logic          handler_o,
   input logic [AW-1:0] mem_addr_o,
   input logic          mem_we_o,
   input logic          mem_re_o,
   input logic          err_o
);
   localparam logic [AW-1:0] STEP = AW'(1) << LSB;

   logic quiet;
   assign quiet = !msp_wr_i && !psp_wr_i && !exc_enter_i && !exc_exit_i && !ctrl_wr_i;

   p_handler_main_r3: assert property (@(posedge clk) disable iff (!rst_n)
      handler_o |-> active_sp_o == msp_o);

   p_push_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i) |-> (mem_we_o && !mem_re_o && mem_addr_o == active_sp_o - STEP));

   p_push_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !pop_i && quiet) |=> active_sp_o == $past(active_sp_o) - STEP);

   p_pop_req_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i) |-> (mem_re_o && !mem_we_o && mem_addr_o == active_sp_o));

   p_pop_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_i && !push_i && quiet) |=> active_sp_o == $past(active_sp_o) + STEP);

   p_clash_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && pop_i) |-> (err_o && !mem_we_o && !mem_re_o));

   p_clash_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && pop_i && !msp_wr_i && !psp_wr_i) |=> (msp_o == $past(msp_o) && psp_o == $past(psp_o)));

   p_aligned_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (msp_o[LSB-1:0] == '0 && psp_o[LSB-1:0] == '0));

   p_enter_r9: assert property (@(posedge clk) disable iff (!rst_n)
      exc_enter_i |=> handler_o);

   p_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_exit_i && !exc_enter_i) |=> !handler_o);

   p_direct_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
      msp_wr_i |=> msp_o[AW-1:LSB] == $past(sp_wdata_i[AW-1:LSB]));
endmodule

bind bsp_unit bsp_unit_chk #(.AW(AW), .LSB(ALIGN_LSB)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .exc_enter_i (exc_enter_i),
   .exc_exit_i  (exc_exit_i),
   .ctrl_wr_i   (ctrl_wr_i),
   .msp_wr_i    (msp_wr_i),
   .psp_wr_i    (psp_wr_i),
   .sp_wdata_i  (sp_wdata_i),
   .push_i      (push_i),
   .pop_i       (pop_i),
   .active_sp_o (active_sp_o),
   .msp_o       (msp_o),
   .psp_o       (psp_o),
   .handler_o   (handler_o),
   .mem_addr_o  (mem_addr_o),
   .mem_we_o    (mem_we_o),
   .mem_re_o    (mem_re_o),
   .err_o       (err_o)
);

// File: tb/bsp_unit_tb.sv
module bsp_unit_tb;
   localparam int AW = 32;
   localparam int DW = 32;
   localparam logic [31:0] MAIN_R = 32'h2000_1000;
   localparam logic [31:0] PROC_R = 32'h2000_0800;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          exc_enter_i = 1'b0, exc_exit_i = 1'b0;
   logic          ctrl_wr_i = 1'b0, ctrl_val_i = 1'b0;
   logic          msp_wr_i = 1'b0, psp_wr_i = 1'b0;
   logic [AW-1:0] sp_wdata_i = '0;
   logic          push_i = 1'b0, pop_i = 1'b0;
   logic [DW-1:0] push_data_i = '0;
   logic [AW-1:0] active_sp_o, msp_o, psp_o, mem_addr_o;
   logic [DW-1:0] mem_wdata_o;
   logic          handler_o, ctrl_o, mem_we_o, mem_re_o, err_o;

   always #10 clk = ~clk;

   bsp_unit #(.AW(AW), .DW(DW), .ALIGN_LSB(2), .MAIN_RST(MAIN_R), .PROC_RST(PROC_R)) u_dut (
      .clk(clk), .rst_n(rst_n), .exc_enter_i(exc_enter_i), .exc_exit_i(exc_exit_i),
      .ctrl_wr_i(ctrl_wr_i), .ctrl_val_i(ctrl_val_i), .msp_wr_i(msp_wr_i), .psp_wr_i(psp_wr_i),
      .sp_wdata_i(sp_wdata_i), .push_i(push_i), .push_data_i(push_data_i), .pop_i(pop_i),
      .active_sp_o(active_sp_o), .msp_o(msp_o), .psp_o(psp_o), .handler_o(handler_o),
      .ctrl_o(ctrl_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
      .mem_we_o(mem_we_o), .mem_re_o(mem_re_o), .err_o(err_o));

   typedef struct {
      logic [31:0] addr;
      logic [31:0] data;
      logic        we;
      logic        re;
      logic        err;
   } mreq_t;

   mreq_t exq[$];
   int checks = 0;
   int errors = 0;
   logic done = 1'b0;

   logic [31:0] m_msp = MAIN_R, m_psp = PROC_R;
   logic        m_hnd = 1'b0, m_ctl = 1'b0;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] m_active();
      return (!m_hnd && m_ctl) ? m_psp : m_msp;
   endfunction

   // monitor: compare every memory request / error with the scoreboard
   always @(negedge clk) begin
      if (rst_n && (mem_we_o || mem_re_o || err_o)) begin
         if (exq.size() == 0) begin
            checks++; errors++;
            $display("FAIL R4/R5/R6 unexpected request actual addr=%h expected none", mem_addr_o);
         end else begin
            mreq_t e;
            e = exq.pop_front();
            check("R4/R5/R6 req.we", {31'd0, mem_we_o}, {31'd0, e.we});
            check("R4/R5/R6 req.re", {31'd0, mem_re_o}, {31'd0, e.re});
            check("R6 req.err", {31'd0, err_o}, {31'd0, e.err});
            if (!e.err) check("R4/R5 req.addr", mem_addr_o, e.addr);
            if (e.we) check("R4 req.data", mem_wdata_o, e.data);
         end
      end
   end

   // one cycle of stimulus; called at posedge+1
   task automatic op(input logic pu, input logic po, input logic [31:0] d,
                     input logic wm, input logic wp, input logic [31:0] wv,
                     input logic en, input logic ex, input logic cw, input logic cv);
      logic [31:0] a;
      logic        tgt_proc;
      mreq_t e;
      a = m_active();
      tgt_proc = !m_hnd && m_ctl;
      push_i = pu; pop_i = po; push_data_i = d;
      msp_wr_i = wm; psp_wr_i = wp; sp_wdata_i = wv;
      exc_enter_i = en; exc_exit_i = ex; ctrl_wr_i = cw; ctrl_val_i = cv;
      if (pu || po) begin
         e.addr = (pu && !po) ? a - 32'd4 : a;
         e.data = d; e.we = pu && !po; e.re = po && !pu; e.err = pu && po;
         exq.push_back(e);
      end
      @(posedge clk); #1;
      push_i = 0; pop_i = 0; msp_wr_i = 0; psp_wr_i = 0;
      exc_enter_i = 0; exc_exit_i = 0; ctrl_wr_i = 0;
      if (pu ^ po) begin
         if (tgt_proc) m_psp = pu ? a - 32'd4 : a + 32'd4;
         else          m_msp = pu ? a - 32'd4 : a + 32'd4;
      end
      if (wm) m_msp = wv & ~32'd3;
      if (wp) m_psp = wv & ~32'd3;
      if (en) m_hnd = 1'b1; else if (ex) m_hnd = 1'b0;
      if (cw) m_ctl = cv;
   endtask

   task automatic check_state(input string tag);
      check({tag, " active"}, active_sp_o, m_active());
      check({tag, " main"}, msp_o, m_msp);
      check({tag, " proc"}, psp_o, m_psp);
      check({tag, " mode"}, {31'd0, handler_o}, {31'd0, m_hnd});
      check({tag, " sel"}, {31'd0, ctrl_o}, {31'd0, m_ctl});
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      check_state("R1 reset");
      check("R1 active is main", active_sp_o, MAIN_R);
      // R4: pushes on main in thread mode
      op(1,0,32'hAAAA_0001, 0,0,0, 0,0,0,0); check_state("R4 push main");
      op(1,0,32'hBBBB_0002, 0,0,0, 0,0,0,0); check_state("R4 push main 2");
      check("R4 main value", msp_o, 32'h2000_0FF8);
      // R5: pop
      op(0,1,0, 0,0,0, 0,0,0,0); check_state("R5 pop main");
      // R2: select process in thread mode
      op(0,0,0, 0,0,0, 0,0,1,1); check_state("R2 select proc");
      check("R2 active is proc", active_sp_o, psp_o);
      op(1,0,32'hC0DE_0003, 0,0,0, 0,0,0,0); check_state("R4 push proc");
      op(0,1,0, 0,0,0, 0,0,0,0); check_state("R5 pop proc");
      // R3 / R9: enter handler, main forced
      op(0,0,0, 0,0,0, 1,0,0,0); check_state("R9 enter");
      check("R3 active main in handler", active_sp_o, msp_o);
      op(1,0,32'hD00D_0004, 0,0,0, 0,0,0,0); check_state("R3 push in handler");
      // R8: select write in handler deferred
      op(0,0,0, 0,0,0, 0,0,1,0); check_state("R8 clear sel in handler");
      op(0,0,0, 0,0,0, 0,1,0,0); check_state("R9 exit");
      check("R8 main after exit", active_sp_o, msp_o);
      op(0,0,0, 0,0,0, 1,0,0,0); check_state("R9 enter 2");
      op(0,0,0, 0,0,0, 0,0,1,1); check_state("R8 set sel in handler");
      check("R8 still main", active_sp_o, msp_o);
      op(0,0,0, 0,0,0, 0,1,0,0); check_state("R8 exit to proc");
      check("R8 proc after exit", active_sp_o, psp_o);
      // R6: clash
      op(1,1,32'h1111_1111, 0,0,0, 0,0,0,0); check_state("R6 clash");
      // R7: unaligned direct writes
      op(0,0,0, 0,1,32'h1234_5677, 0,0,0,0); check_state("R7 write proc");
      check("R7 low bits dropped", psp_o, 32'h1234_5674);
      op(0,0,0, 1,0,32'h3000_0003, 0,0,0,0); check_state("R7 write main");
      // R10: direct write beats push on active (proc)
      op(1,0,32'h5555_0005, 0,1,32'h4000_0000, 0,0,0,0); check_state("R10 write wins");
      check("R10 proc value", psp_o, 32'h4000_0000);
      // R9: enter and exit together -> handler
      op(0,0,0, 0,0,0, 1,1,0,0); check_state("R9 enter wins");
      // R4 wraparound on main
      op(0,0,0, 1,0,32'h0000_0000, 0,0,0,0); check_state("R7 main zero");
      op(1,0,32'h7777_0007, 0,0,0, 0,0,0,0); check_state("R4 wrap");
      check("R4 wrap value", msp_o, 32'hFFFF_FFFC);
      op(0,1,0, 0,0,0, 0,0,0,0); check_state("R5 pop wrap");
      @(posedge clk); #1;
      checks++;
      if (exq.size() != 0) begin
         errors++;
         $display("FAIL R4/R5 scoreboard left=%0d expected=0", exq.size());
      end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule